// File: doc/BRIEF.md
# Hardware ticket lock unit

This block is a single shared lock that serves a fixed number of requester ports and hands the lock out strictly in the order the requests arrived. It holds two wrapping counters. One gives the ticket that the next acquire will receive. The other gives the ticket that currently owns the lock. A port that raises its acquire line is handed the current issue value, and the issue counter steps forward.

The port keeps that ticket in its own slot register. It sees its grant flag rise once the serving counter reaches its ticket. The grant holder ends its turn by pulsing its release line, which moves the serving counter forward by exactly one. That single step passes the lock to the next ticket holder.

Acquires that arrive on several ports in the same cycle are ordered inside the block. Each such port still receives a distinct ticket, so ticket issue stays atomic. A release from a port that does not hold the lock has no effect on the lock state and is reported on an error pulse.

Top module: `ticket_lock_unit`

## Requirements
- R1: After synchronous reset, no port is granted, `bad_release` is low, and both counters are zero, so the first accepted acquire receives ticket 0.
- R2: An accepted acquire loads the port's ticket (visible on its `ticket_o` field, bits `[i*TW +: TW]`, from the cycle after the request) with the current issue value and advances the issue counter by one.
- R3: Acquires accepted in the same cycle receive consecutive tickets in ascending port-index order, and the issue counter advances by the number accepted.
- R4: `granted[i]` is high exactly when port i holds a ticket and that ticket equals the serving value, and at most one port is granted at any time.
- R5: A release from the granted port advances the serving counter by one and clears that port's slot, so the holder of the next ticket is granted in the cycle after the release edge.
- R6: A release from a port that is not granted changes no ticket, slot or counter, and `bad_release` is high for exactly the cycle after that release edge.
- R7: An acquire from a port that already holds or waits on a ticket is ignored: its ticket is unchanged and the issue counter does not advance for it.
- R8: Both counters are TW = clog2(N)+1 bits wide and wrap modulo 2^TW, and the grant comparison uses the wrapped values, so the lock order continues unchanged past the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | N | Per-port acquire request, sampled each rising edge |
| rel_req | input | N | Per-port release request, sampled each rising edge |
| ticket_o | output | N*TW | Per-port ticket held in the slot; field i at bits [i*TW +: TW] |
| granted | output | N | Per-port lock-held flag |
| bad_release | output | 1 | One-cycle pulse after a release from a non-holding port |

## Verification
The embedded properties assume only that requests are synchronous to the clock. They assume no protocol discipline from the requesters: repeated acquires, releases from waiting or idle ports, and several releases in one cycle are all legal stimulus. These are exactly the cases the properties must survive. The stimulus therefore mixes directed sequences (a lone acquire, a batch of simultaneous acquires, a repeated acquire, a stray release) with a long pseudo-random phase. In that phase the acquire pattern is free, releases mostly come from the true holder, and stray releases are injected now and then. The random phase runs long enough that both counters wrap several times.

// File: rtl/tkl_pkg.sv
package tkl_pkg;

    // Occupancy of one requester slot; "holding" is derived from WAIT plus a ticket match.
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_WAIT = 1'b1
    } slot_state_e;

    // Outcome of the release stage for one cycle.
    typedef struct packed {
        logic advance;   // serving counter steps by one
        logic fault;     // some release came from a non-holder
    } rel_result_t;

    function automatic int unsigned ticket_width(input int unsigned ports);
        return $clog2(ports) + 1;
    endfunction

endpackage

// File: rtl/tkl_issue.sv
module tkl_issue #(
    parameter int N  = 4,
    parameter int TW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         acq_ok,
    output logic [N-1:0][TW-1:0] offer,
    output logic [TW-1:0]        next_q
);
    logic [TW-1:0] next_d;

    // Ripple the issue value up through the ports: lower index gets the lower ticket.
    always_comb begin
        logic [TW-1:0] run;
        run = next_q;
        for (int i = 0; i < N; i++) begin
            offer[i] = run;
            if (acq_ok[i]) run = run + TW'(1);
        end
        next_d = run;
    end

    always_ff @(posedge clk) begin
        if (rst) next_q <= '0;
        else     next_q <= next_d;
    end

    // Issue counter advances by the number of accepted acquires, modulo 2^TW
    assert_issue_count_R3: assert property (@(posedge clk) disable iff (rst)
        1 |=> next_q == TW'($past(next_q) + TW'($countones($past(acq_ok)))));

endmodule

// File: rtl/tkl_slot.sv
module tkl_slot
    import tkl_pkg::*;
#(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acq,
    input  logic [TW-1:0] offer,
    input  logic [TW-1:0] serving,
    input  logic          release_ok,
    output logic          acq_ok,
    output logic          busy,
    output logic          holds,
    output logic [TW-1:0] ticket
);
    slot_state_e state_q;

    assign busy   = (state_q == SLOT_WAIT);
    assign acq_ok = acq && !busy;
    assign holds  = busy && (ticket == serving);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_IDLE;
            ticket  <= '0;
        end else if (release_ok) begin
            state_q <= SLOT_IDLE;
        end else if (acq_ok) begin
            state_q <= SLOT_WAIT;
            ticket  <= offer;
        end
    end

    // A repeated acquire while occupied leaves the ticket alone
    assert_busy_acq_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && acq && !release_ok) |=> (busy && $stable(ticket)));

    // Only a slot that holds the lock may be released
    assert_release_holder_R5: assert property (@(posedge clk) disable iff (rst)
        release_ok |-> holds);

endmodule

// File: rtl/tkl_serve.sv
module tkl_serve
    import tkl_pkg::*;
#(
    parameter int N  = 4,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  rel_req,
    input  logic [N-1:0]  holds,
    output logic [N-1:0]  release_ok,
    output logic [TW-1:0] serving_q,
    output logic          err_q
);
    rel_result_t res;

    assign release_ok  = rel_req & holds;
    assign res.advance = |release_ok;
    assign res.fault   = |(rel_req & ~holds);

    always_ff @(posedge clk) begin
        if (rst) begin
            serving_q <= '0;
            err_q     <= 1'b0;
        end else begin
            if (res.advance) serving_q <= serving_q + TW'(1);
            err_q <= res.fault;
        end
    end

    // Serving counter only ever holds or steps by one
    assert_serve_step_R5: assert property (@(posedge clk) disable iff (rst)
        1 |=> (serving_q == $past(serving_q)) ||
              (serving_q == TW'($past(serving_q) + TW'(1))));

    // A stray release is flagged on the next cycle
    assert_stray_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (|(rel_req & ~holds)) |=> err_q);

    // Without any stray release the flag stays low next cycle
    assert_stray_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !(|(rel_req & ~holds)) |=> !err_q);

endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
    import tkl_pkg::*;
#(
    parameter int N  = 4,
    parameter int TW = ticket_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  acq_req,
    input  logic [N-1:0]  rel_req,
    output logic [N*TW-1:0] ticket_o,
    output logic [N-1:0]  granted,
    output logic          bad_release
);
    logic [N-1:0]         acq_ok;
    logic [N-1:0]         busy;
    logic [N-1:0]         holds;
    logic [N-1:0]         release_ok;
    logic [N-1:0][TW-1:0] offer;
    logic [TW-1:0]        next_q;
    logic [TW-1:0]        serving_q;

    tkl_issue #(.N(N), .TW(TW)) u_issue (
        .clk    (clk),
        .rst    (rst),
        .acq_ok (acq_ok),
        .offer  (offer),
        .next_q (next_q)
    );

    for (genvar g = 0; g < N; g++) begin : g_slot
        tkl_slot #(.TW(TW)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .acq        (acq_req[g]),
            .offer      (offer[g]),
            .serving    (serving_q),
            .release_ok (release_ok[g]),
            .acq_ok     (acq_ok[g]),
            .busy       (busy[g]),
            .holds      (holds[g]),
            .ticket     (ticket_o[g*TW +: TW])
        );
    end

    tkl_serve #(.N(N), .TW(TW)) u_serve (
        .clk        (clk),
        .rst        (rst),
        .rel_req    (rel_req),
        .holds      (holds),
        .release_ok (release_ok),
        .serving_q  (serving_q),
        .err_q      (bad_release)
    );

    assign granted = holds;

    // Mutual exclusion: never two holders
    assert_one_holder_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(granted));

    // Outstanding tickets never exceed the port count, so wrapped compare stays unambiguous
    assert_window_R8: assert property (@(posedge clk) disable iff (rst)
        TW'(next_q - serving_q) <= TW'(N));

    // Tickets outstanding equal occupied slots
    assert_occupancy_R2: assert property (@(posedge clk) disable iff (rst)
        int'(TW'(next_q - serving_q)) == $countones(busy));

endmodule

// File: tb/ticket_lock_unit_test.sv
module ticket_lock_unit_test;
    localparam int N  = 4;
    localparam int TW = $clog2(N) + 1;
    localparam int M  = 1 << TW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    acq_req = '0;
    logic [N-1:0]    rel_req = '0;
    logic [N*TW-1:0] ticket_o;
    logic [N-1:0]    granted;
    logic            bad_release;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference state
    int  m_next = 0;
    int  m_serve = 0;
    int  m_tick [N];
    bit  m_wait [N];
    bit  m_err = 0;
    int  wraps = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    ticket_lock_unit #(.N(N)) uut (
        .clk(clk), .rst(rst), .acq_req(acq_req), .rel_req(rel_req),
        .ticket_o(ticket_o), .granted(granted), .bad_release(bad_release)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_grant();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_wait[i] && (m_tick[i] == m_serve);
        return v;
    endfunction

    task automatic model_step(input logic [N-1:0] a, input logic [N-1:0] r);
        bit pw [N];
        int pt [N];
        int sv;
        for (int i = 0; i < N; i++) begin pw[i] = m_wait[i]; pt[i] = m_tick[i]; end
        sv = m_serve;
        m_err = 0;
        for (int i = 0; i < N; i++) begin
            if (r[i]) begin
                if (pw[i] && pt[i] == sv) begin
                    m_serve = (m_serve + 1) % M;
                    m_wait[i] = 0;
                end else m_err = 1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (a[i] && !pw[i]) begin
                m_tick[i] = m_next;
                m_wait[i] = 1;
                m_next = (m_next + 1) % M;
                if (m_next == 0) wraps++;
            end
        end
    endtask

    task automatic compare_all();
        check("R4", "granted", int'(granted), int'(model_grant()));
        check("R6", "bad_release", int'(bad_release), int'(m_err));
        for (int i = 0; i < N; i++)
            if (m_wait[i])
                check(tag, $sformatf("ticket port %0d", i),
                      int'(ticket_o[i*TW +: TW]), m_tick[i]);
    endtask

    task automatic cycle(input logic [N-1:0] a, input logic [N-1:0] r);
        acq_req = a;
        rel_req = r;
        @(posedge clk);
        model_step(a, r);
        @(negedge clk);
        acq_req = '0;
        rel_req = '0;
        compare_all();
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < N; i++) begin m_tick[i] = 0; m_wait[i] = 0; end
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "granted after reset", int'(granted), 0);
        check("R1", "bad_release after reset", int'(bad_release), 0);

        // R1/R2: lone acquire gets ticket 0 and is granted at once
        tag = "R2";
        cycle(4'b0100, '0);
        check("R1", "first ticket", int'(ticket_o[2*TW +: TW]), 0);
        check("R2", "port 2 granted", int'(granted), 4'b0100);

        // R3: simultaneous acquires get consecutive tickets in port order
        tag = "R3";
        cycle(4'b1011, '0);
        check("R3", "port 0 ticket", int'(ticket_o[0*TW +: TW]), 1);
        check("R3", "port 1 ticket", int'(ticket_o[1*TW +: TW]), 2);
        check("R3", "port 3 ticket", int'(ticket_o[3*TW +: TW]), 3);

        // R7: repeated acquire from a waiting port is ignored; next fresh acquire proves counter held
        tag = "R7";
        cycle(4'b0001, '0);
        check("R7", "port 0 ticket kept", int'(ticket_o[0*TW +: TW]), 1);

        // R6: stray release from waiting port 1
        tag = "R6";
        cycle('0, 4'b0010);
        check("R6", "stray flag", int'(bad_release), 1);
        check("R6", "holder unchanged", int'(granted), 4'b0100);
        cycle('0, '0);
        check("R6", "flag single cycle", int'(bad_release), 0);

        // R5: holder releases; next ticket (port 0) granted
        tag = "R5";
        cycle('0, 4'b0100);
        check("R5", "next holder", int'(granted), 4'b0001);
        // port 2 re-acquires: issue counter was not advanced by the ignored acquire (R7)
        cycle(4'b0100, '0);
        check("R7", "issue counter held", int'(ticket_o[2*TW +: TW]), 4);
        cycle('0, 4'b0001);
        check("R5", "third holder", int'(granted), 4'b0010);

        // R8: long mixed run wrapping the counters
        tag = "R8";
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] a, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[3:0];
            if (lfsr[7:5] == 3'd0) r = lfsr[11:8];
            else if (lfsr[4]) r = model_grant();
            else r = '0;
            cycle(a, r);
        end
        check("R8", "counters wrapped at least twice", int'(wraps >= 2), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule